// File: doc/BRIEF.md
# Twin-Port Byte Store with Auto-Stepping Pointers

The block is a 256-byte store reached through two pointers. The left pointer addresses a port that can read and write. The right pointer addresses a port that only reads, and that port feeds the instruction bus. One 8-bit switch/data input carries both addresses and data. In one cycle the input loads a pointer, and in a later cycle it supplies the byte to be stored. Each pointer can also step forward by one on every clock edge, so a sequence of cycles walks through consecutive locations without reloading.

All state changes happen on the rising edge of `clk`, which is the write-phase strobe of the surrounding datapath. The input byte acts only when `sw_drive` gates it onto the internal bus. The stored bytes reach the two output buses only while `mem_drive` is high. At all other times both output buses are zero. An asynchronous active-low clear returns both pointers to location 0. It leaves the stored bytes untouched.

Top module: `twin_port_store`

## Requirements
- R1: While `mem_drive` is 0, both `data_bus` and `instr_bus` are 8'h00.
- R2: Driving `clr_n` low sets both pointers to 0 at once, without waiting for a clock edge. The stored bytes keep their values.
- R3: At a rising edge with `left_load`=1 and `sw_drive`=1, the left pointer takes the value of `sd_in`. With `right_load`=1 and `sw_drive`=1, the right pointer does the same. A pointer with neither load nor step keeps its value.
- R4: At a rising edge with `store_en`=1 and `sw_drive`=1, `sd_in` is written into the location addressed by the left pointer. The pointer value used is the one held before that edge.
- R5: While `mem_drive` is 1, `data_bus` shows the byte at the left pointer's location, in the same cycle.
- R6: While `mem_drive` is 1, `instr_bus` shows the byte at the right pointer's location, in the same cycle.
- R7: At a rising edge with `left_step`=1 and no left load, the left pointer increases by 1. It wraps from 8'hFF to 8'h00.
- R8: At a rising edge with `right_step`=1 and no right load, the right pointer increases by 1. It wraps from 8'hFF to 8'h00.
- R9: When a load and a step are requested for the same pointer at the same edge, the load wins and the pointer takes `sd_in`.
- R10: The right port never writes. A write changes only the location at the left pointer, even when the right pointer addresses a different location.
- R11: When a write hits the location the right pointer addresses, `instr_bus` shows the new byte in the next cycle.
- R12: Without `sw_drive`, both `store_en` and the load requests are ignored. No byte is written and no pointer is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-phase strobe. All updates occur on its rising edge |
| clr_n | input | 1 | Asynchronous active-low clear of both pointers |
| sd_in | input | 8 | Shared address/data switch input |
| sw_drive | input | 1 | Gates `sd_in` onto the internal bus for loads and writes |
| left_load | input | 1 | Load the left pointer from `sd_in` |
| right_load | input | 1 | Load the right pointer from `sd_in` |
| store_en | input | 1 | Write `sd_in` at the left pointer's location |
| mem_drive | input | 1 | Put both port read values on the output buses |
| left_step | input | 1 | Advance the left pointer by one |
| right_step | input | 1 | Advance the right pointer by one |
| data_bus | output | 8 | Left-port read data, or zero |
| instr_bus | output | 8 | Right-port read data, or zero |

## Verification
A wrong pointer value shows at the ports in the first cycle that `mem_drive` is raised. The reads are combinational, so the wrong address is visible in that same cycle, because the location pattern preloaded by the bench differs between neighbouring addresses. A wrong write shows up when that location is later read from either port. The bench therefore keeps `mem_drive` high through most of the pointer walks, compares both buses against a behavioural model on every clock, and reads a written location back through the right port one cycle after the write.

// File: rtl/twin_port_pkg.sv
package twin_port_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    // Request pair driving one pointer for one edge
    typedef struct packed {
        logic load;
        logic step;
    } ptr_cmd_t;

endpackage

// File: rtl/ptr_counter.sv
module ptr_counter
    import twin_port_pkg::*;
#(
    parameter int WIDTH = ADDR_W
) (
    input  logic             clk,
    input  logic             clr_n,
    input  ptr_cmd_t         cmd,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] ptr
);

    typedef struct packed {
        logic [WIDTH-1:0] val;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd.load) begin
            st_d.val = load_val;
        end else if (cmd.step) begin
            st_d.val = st_q.val + WIDTH'(1);
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr = st_q.val;

    // R9: a load request overrides a step request
    p_load_wins_r9: assert property (@(posedge clk) disable iff (!clr_n)
        cmd.load |=> (ptr == $past(load_val)));

    // R7 / R8: a step without a load advances by one, wrapping
    p_step_by_one_r7: assert property (@(posedge clk) disable iff (!clr_n)
        (!cmd.load && cmd.step) |=> (ptr == $past(ptr) + WIDTH'(1)));

    // R3: an idle pointer holds its value
    p_idle_holds_r3: assert property (@(posedge clk) disable iff (!clr_n)
        (!cmd.load && !cmd.step) |=> $stable(ptr));

endmodule

// File: rtl/byte_store.sv
module byte_store
    import twin_port_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          clr_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    // Contents are not cleared: only the pointers respond to the clear
    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];

    // R4: the written byte lands at the write address
    p_write_lands_r4: assert property (@(posedge clk) disable iff (!clr_n)
        we |=> (mem_q[$past(waddr)] == $past(wdata)));

    // R10 / R12: with no write, the byte under the read-only port is unchanged
    p_no_write_keeps_r10: assert property (@(posedge clk) disable iff (!clr_n)
        (!we && !$isunknown(rdata_b)) |=> (mem_q[$past(raddr_b)] == $past(rdata_b)));

endmodule

// File: rtl/twin_port_store.sv
module twin_port_store
    import twin_port_pkg::*;
(
    input  logic              clk,
    input  logic              clr_n,
    input  logic [DATA_W-1:0] sd_in,
    input  logic              sw_drive,
    input  logic              left_load,
    input  logic              right_load,
    input  logic              store_en,
    input  logic              mem_drive,
    input  logic              left_step,
    input  logic              right_step,
    output logic [DATA_W-1:0] data_bus,
    output logic [DATA_W-1:0] instr_bus
);

    ptr_cmd_t          left_cmd, right_cmd;
    logic [ADDR_W-1:0] left_ptr, right_ptr;
    logic [DATA_W-1:0] left_rd, right_rd;
    logic              write_fire;

    always_comb begin
        left_cmd.load  = left_load && sw_drive;
        left_cmd.step  = left_step;
        right_cmd.load = right_load && sw_drive;
        right_cmd.step = right_step;
        write_fire     = store_en && sw_drive;
    end

    ptr_counter #(.WIDTH(ADDR_W)) u_left_ptr (
        .clk      (clk),
        .clr_n    (clr_n),
        .cmd      (left_cmd),
        .load_val (ADDR_W'(sd_in)),
        .ptr      (left_ptr)
    );

    ptr_counter #(.WIDTH(ADDR_W)) u_right_ptr (
        .clk      (clk),
        .clr_n    (clr_n),
        .cmd      (right_cmd),
        .load_val (ADDR_W'(sd_in)),
        .ptr      (right_ptr)
    );

    byte_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
        .clk     (clk),
        .clr_n   (clr_n),
        .we      (write_fire),
        .waddr   (left_ptr),
        .wdata   (sd_in),
        .raddr_a (left_ptr),
        .rdata_a (left_rd),
        .raddr_b (right_ptr),
        .rdata_b (right_rd)
    );

    always_comb begin
        data_bus  = mem_drive ? left_rd  : '0;
        instr_bus = mem_drive ? right_rd : '0;
    end

    // R11: a write under the right pointer is visible there next cycle
    p_instr_follows_write_r11: assert property (@(posedge clk) disable iff (!clr_n)
        (write_fire && (left_ptr == right_ptr) && !right_cmd.load && !right_step)
        |=> (!mem_drive || instr_bus == $past(sd_in)));

endmodule

// File: tb/twin_port_store_bench.sv
module twin_port_store_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       clr_n;
    logic [7:0] sd_in;
    logic       sw_drive, left_load, right_load, store_en;
    logic       mem_drive, left_step, right_step;
    logic [7:0] data_bus, instr_bus;

    always #(CLK_PERIOD/2) clk = ~clk;

    twin_port_store u_twin_port_store (
        .clk(clk), .clr_n(clr_n), .sd_in(sd_in), .sw_drive(sw_drive),
        .left_load(left_load), .right_load(right_load), .store_en(store_en),
        .mem_drive(mem_drive), .left_step(left_step), .right_step(right_step),
        .data_bus(data_bus), .instr_bus(instr_bus)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string tag    = "R1";

    // Behavioural reference: byte array plus two integer pointers
    bit [7:0] m_mem [256];
    int       m_left  = 0;
    int       m_right = 0;

    always @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            m_left  <= 0;
            m_right <= 0;
        end else begin
            if (store_en && sw_drive) m_mem[m_left] <= sd_in;
            if (left_load && sw_drive) m_left <= int'(sd_in);
            else if (left_step)        m_left <= (m_left + 1) % 256;
            if (right_load && sw_drive) m_right <= int'(sd_in);
            else if (right_step)        m_right <= (m_right + 1) % 256;
        end
    end

    task automatic check_ports();
        logic [7:0] exp_d, exp_i;
        exp_d = mem_drive ? m_mem[m_left]  : 8'h00;
        exp_i = mem_drive ? m_mem[m_right] : 8'h00;
        checks++;
        if (data_bus !== exp_d) begin
            fails++;
            $display("FAIL %s data_bus got %02h expected %02h", tag, data_bus, exp_d);
        end
        checks++;
        if (instr_bus !== exp_i) begin
            fails++;
            $display("FAIL %s instr_bus got %02h expected %02h", tag, instr_bus, exp_i);
        end
    endtask

    task automatic tick();
        #(CLK_PERIOD/4);
        check_ports();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic ll, input logic rl, input logic we,
                         input logic sw, input logic md, input logic ls,
                         input logic rs, input logic [7:0] d);
        left_load = ll; right_load = rl; store_en = we; sw_drive = sw;
        mem_drive = md; left_step = ls; right_step = rs; sd_in = d;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        clr_n = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 0, 8'h00);
        @(negedge clk);
        tag = "R1"; tick();                       // reset state, idle buses zero
        clr_n = 1'b1;
        // r2_: pointers at 0 after clear, write there without a load
        tag = "R2"; drive(0, 0, 1, 1, 0, 0, 0, 8'hA5); tick();
        tag = "R2"; drive(0, 0, 0, 0, 1, 0, 0, 8'h00); tick();
        // r4_ / r7_: fill every location by stepping the left pointer, wraps to 0
        tag = "R4";
        for (int i = 0; i < 256; i++) begin
            drive(0, 0, 1, 1, 0, 1, 0, 8'((i * 7 + 3) ^ 8'h5C));
            tick();
        end
        tag = "R7"; drive(0, 0, 0, 0, 1, 0, 0, 8'h00); tick();
        // r3_ / r5_: load left pointer then walk reads
        tag = "R3"; drive(1, 0, 0, 1, 0, 0, 0, 8'h10); tick();
        tag = "R5";
        for (int i = 0; i < 8; i++) begin drive(0, 0, 0, 0, 1, 1, 0, 8'h00); tick(); end
        // r6_ / r8_: right pointer load near top, walk across the wrap
        tag = "R6"; drive(0, 1, 0, 1, 1, 0, 0, 8'hFD); tick();
        tag = "R8";
        for (int i = 0; i < 6; i++) begin drive(0, 0, 0, 0, 1, 0, 1, 8'h00); tick(); end
        // r9_: load and step together, load wins
        tag = "R9"; drive(1, 1, 0, 1, 1, 1, 1, 8'h40); tick();
        tag = "R9"; drive(0, 0, 0, 0, 1, 0, 0, 8'h00); tick();
        // r12_: requests without the switch gate are ignored
        tag = "R12"; drive(1, 1, 1, 0, 1, 0, 0, 8'hEE); tick();
        tag = "R12"; drive(0, 0, 0, 0, 1, 0, 0, 8'h00); tick();
        // r10_: pointers apart, write left, right byte stays
        tag = "R10"; drive(1, 0, 0, 1, 1, 0, 0, 8'h60); tick();
        tag = "R10"; drive(0, 1, 0, 1, 1, 0, 0, 8'h50); tick();
        tag = "R10"; drive(0, 0, 1, 1, 1, 0, 0, 8'h77); tick();
        tag = "R10"; drive(0, 0, 0, 0, 1, 0, 0, 8'h00); tick();
        // r11_: both pointers on one location, write then see on instr_bus
        tag = "R11"; drive(1, 1, 0, 1, 1, 0, 0, 8'h33); tick();
        tag = "R11"; drive(0, 0, 1, 1, 1, 0, 0, 8'h99); tick();
        tag = "R11"; drive(0, 0, 0, 0, 1, 0, 0, 8'h00); tick();
        // r2_: asynchronous clear mid-run, contents kept
        tag = "R2"; drive(0, 0, 0, 0, 1, 0, 0, 8'h00); clr_n = 1'b0; tick();
        clr_n = 1'b1;
        tag = "R1"; drive(0, 0, 0, 0, 0, 1, 1, 8'h00); tick();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule